// File: doc/BRIEF.md
# Byte-Laned Static Memory Model

This block is a synthesizable, cycle-level model of a 16-bit static memory. It is built to be the target device when a static-memory controller is checked. It takes the usual asynchronous-memory pin set: an active-low select, an active-high select, an active-low output enable, a read/write line, and one active-low strobe per byte. The bidirectional data bus is split into three parts: a data input, a data output and a drive enable for each byte lane.

The selects, strobes, read/write line and output enable are decoded into one of four modes: standby, no-drive, read and write. A write stores only the bytes whose strobe is low, at the clock edge where the write condition is sampled. Read data comes straight from the array at the current address, with no register on the path. A lane that is not driven shows zero on its data-out bits. The address width is a parameter, so a bench can use a small array. The full-size device uses 18 address bits. The default is 10, which keeps elaboration small.

Top module: `sram_bytelane_model`

## Requirements
- R1: `standby` is 1 exactly when `sel_n` is 1 or `sel` is 0, whatever the other inputs are.
- R2: In standby, both bits of `lane_oe` are 0 and no byte of the array changes at the clock edge.
- R3: When the device is selected and both `hi_n` and `lo_n` are 1, `lane_oe` is 0 and nothing is written.
- R4: A selected read (`rd_wr_n`=1, `out_en_n`=0) sets `lane_oe[0]` when `lo_n`=0 and `lane_oe[1]` when `hi_n`=0. The driven lanes show the stored word at the current `addr` in the same cycle: lane 0 on `dout[7:0]` and lane 1 on `dout[15:8]`.
- R5: A selected read with `out_en_n`=1 drives neither lane.
- R6: A selected write (`rd_wr_n`=0) stores `din[7:0]` when `lo_n`=0 and `din[15:8]` when `hi_n`=0 into word `addr` at the rising clock edge. This happens whatever the level of `out_en_n`. A lane whose strobe is 1 keeps its old contents.
- R7: While a selected write is presented, both bits of `lane_oe` are 0.
- R8: The `dout` bits of a lane whose `lane_oe` bit is 0 are zero.
- R9: While `rst` is 1, no write reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| out_en_n | input | 1 | Active-low output enable |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| hi_n | input | 1 | Active-low strobe for bits 15:8 |
| lo_n | input | 1 | Active-low strobe for bits 7:0 |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; zero on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable, bit 0 = low byte |
| standby | output | 1 | High while the select pair deselects the device |

## Verification
The bench covers three groups of corner cases:
- A write attempted in standby, or with both strobes high, must leave the array untouched. A decode that let the write through would corrupt a word that a later read checks.
- A byte write must leave the other byte intact. A model that wrote the whole word would fail the read-back of the neighbouring byte.
- A write must take place, and float both lanes, even with the output enable low. A model that treated that case as a read would drive the bus against the controller.

Reads with the output enable high, writes attempted during reset, and a long pseudo-random sweep are each checked against a behavioural word array on every cycle.

// File: rtl/sram_model_pkg.sv
`timescale 1ns/1ps
package sram_model_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_NODRIVE = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } mode_e;

    typedef struct packed {
        logic             sel_n;
        logic             sel;
        logic             out_en_n;
        logic             rd_wr_n;
        logic [LANES-1:0] strobe_n;   // bit 0 = low byte, bit 1 = high byte
    } ctl_t;

    function automatic logic deselected(input ctl_t c);
        return c.sel_n | ~c.sel;
    endfunction

    function automatic mode_e decode_mode(input ctl_t c);
        mode_e m;
        if (deselected(c))
            m = MODE_STANDBY;
        else if (&c.strobe_n)
            m = MODE_NODRIVE;
        else if (!c.rd_wr_n)
            m = MODE_WRITE;
        else if (!c.out_en_n)
            m = MODE_READ;
        else
            m = MODE_NODRIVE;
        return m;
    endfunction

endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
    import sram_model_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    output logic [LANES-1:0] lane_drive,
    output logic [LANES-1:0] lane_write,
    output logic             standby
);

    mode_e mode;

    always_comb begin
        mode    = decode_mode(ctl);
        standby = (mode == MODE_STANDBY);
    end

    for (genvar li = 0; li < LANES; li++) begin : g_lane_ctl
        always_comb begin
            lane_drive[li] = (mode == MODE_READ)  && !ctl.strobe_n[li];
            lane_write[li] = (mode == MODE_WRITE) && !ctl.strobe_n[li] && !rst;
        end
    end

    AST_STRB_OFF: assert property (@(posedge clk) disable iff (rst)
        (&ctl.strobe_n) |-> (lane_drive == '0 && lane_write == '0)) // R3
        else $error("both strobes high but a lane is active");

    AST_DRV_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        (lane_drive & lane_write) == '0) // R7
        else $error("a lane drives and writes at once");

endmodule

// File: rtl/sram_byte_lane.sv
`timescale 1ns/1ps
module sram_byte_lane #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr)
            cells[addr] <= wdata;
    end

    always_comb rdata = drive ? cells[addr] : '0;

    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cells[$past(addr)] == $past(wdata))) // R6
        else $error("byte write did not land");

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (cells[$past(addr)] == $past(cells[addr]))) // R2
        else $error("byte changed without a write");

    AST_RST_NO_WR: assert property (@(posedge clk)
        rst |-> !wr) // R9
        else $error("write enable during reset");

endmodule

// File: rtl/sram_bytelane_model.sv
`timescale 1ns/1ps
module sram_bytelane_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              out_en_n,
    input  logic              rd_wr_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        lane_oe,
    output logic              standby
);

    ctl_t             ctl;
    logic [LANES-1:0] lane_write;
    logic [LANES-1:0] lane_drive;

    always_comb begin
        ctl.sel_n    = sel_n;
        ctl.sel      = sel;
        ctl.out_en_n = out_en_n;
        ctl.rd_wr_n  = rd_wr_n;
        ctl.strobe_n = {hi_n, lo_n};
    end

    sram_mode_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .lane_drive (lane_drive),
        .lane_write (lane_write),
        .standby    (standby)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        sram_byte_lane #(
            .ADDR_W (ADDR_W),
            .DATA_W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .addr  (addr),
            .wr    (lane_write[gi]),
            .drive (lane_drive[gi]),
            .wdata (din[gi*LANE_W +: LANE_W]),
            .rdata (dout[gi*LANE_W +: LANE_W])
        );
    end

    always_comb lane_oe = lane_drive;

    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        standby |-> (lane_oe == 2'b00 && lane_write == '0)) // R2
        else $error("activity while in standby");

    AST_WR_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && sel && !rd_wr_n) |-> (lane_oe == 2'b00)) // R7
        else $error("lane driven during a write");

    AST_STBY_PINS: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !sel) |-> standby) // R1
        else $error("standby missing while deselected");

endmodule

// File: tb/tb_sram_bytelane_model.sv
`timescale 1ns/1ps
module tb_sram_bytelane_model;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_n, sel, out_en_n, rd_wr_n, hi_n, lo_n;
    logic [AW-1:0] addr;
    logic [15:0]   din;
    logic [15:0]   dout;
    logic [1:0]    lane_oe;
    logic          standby;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] ref_mem [WORDS];

    always #2 clk = ~clk;   // 250 MHz

    sram_bytelane_model #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .out_en_n(out_en_n),
        .rd_wr_n(rd_wr_n), .hi_n(hi_n), .lo_n(lo_n), .addr(addr), .din(din),
        .dout(dout), .lane_oe(lane_oe), .standby(standby)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational outputs,
    // then update the reference array at the rising edge.
    task automatic step(input logic r, input logic sn, input logic s, input logic oen,
                        input logic rwn, input logic hn, input logic ln,
                        input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        logic        e_stby;
        logic [1:0]  e_oe, e_we;
        logic [15:0] e_dout;
        @(negedge clk);
        rst = r; sel_n = sn; sel = s; out_en_n = oen; rd_wr_n = rwn;
        hi_n = hn; lo_n = ln; addr = a; din = d;
        #1;
        e_stby = sn | ~s;
        for (int i = 0; i < 2; i++) begin
            logic strb_on;
            strb_on = (i == 0) ? !ln : !hn;
            e_oe[i] = !e_stby && strb_on && rwn && !oen;
            e_we[i] = !e_stby && strb_on && !rwn && !r;
        end
        e_dout = 16'h0000;
        if (e_oe[0]) e_dout[7:0]  = ref_mem[a][7:0];
        if (e_oe[1]) e_dout[15:8] = ref_mem[a][15:8];
        check(tag, "standby", int'(standby), int'(e_stby));
        check(tag, "lane_oe", int'(lane_oe), int'(e_oe));
        check(tag, "dout",    int'(dout),    int'(e_dout));
        @(posedge clk);
        if (e_we[0]) ref_mem[a][7:0]  = d[7:0];
        if (e_we[1]) ref_mem[a][15:8] = d[15:8];
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h0101) ^ 16'h5A3C;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'h0000;
        rst = 1; sel_n = 1; sel = 0; out_en_n = 1; rd_wr_n = 1;
        hi_n = 1; lo_n = 1; addr = '0; din = '0;

        // Reset state: deselected, nothing driven (R1)
        step(1, 1, 0, 1, 1, 1, 1, 0, 0, "R1 reset");
        step(1, 1, 0, 1, 1, 1, 1, 0, 0, "R1 reset");

        // Fill the array with full-word writes, alternating out_en_n (R6, R7)
        for (int i = 0; i < WORDS; i++)
            step(0, 0, 1, i[0], 0, 0, 0, AW'(i), pat(i), "R6 R7 fill");

        // Full and single-lane reads (R4, R8)
        step(0, 0, 1, 0, 1, 0, 0, 6'd9,  0, "R4 word read");
        step(0, 0, 1, 0, 1, 1, 0, 6'd10, 0, "R4 R8 low read");
        step(0, 0, 1, 0, 1, 0, 1, 6'd11, 0, "R4 R8 high read");

        // Byte writes keep the other lane (R6)
        step(0, 0, 1, 1, 0, 1, 0, 6'd3, 16'hEEAA, "R6 low write");
        step(0, 0, 1, 0, 1, 0, 0, 6'd3, 0, "R6 low readback");
        step(0, 0, 1, 0, 0, 0, 1, 6'd4, 16'hBBEE, "R6 R7 high write oe low");
        step(0, 0, 1, 0, 1, 0, 0, 6'd4, 0, "R6 high readback");

        // Output enable high on a read (R5)
        step(0, 0, 1, 1, 1, 0, 0, 6'd4, 0, "R5 oe high");

        // Standby combinations with write attempts (R1, R2)
        step(0, 1, 1, 0, 0, 0, 0, 6'd5, 16'hFFFF, "R1 R2 sel_n high");
        step(0, 0, 0, 0, 0, 0, 0, 6'd5, 16'hFFFF, "R1 R2 sel low");
        step(0, 1, 0, 0, 0, 0, 0, 6'd5, 16'hFFFF, "R1 R2 both");
        step(0, 0, 1, 0, 1, 0, 0, 6'd5, 0, "R2 readback");

        // Both strobes high (R3)
        step(0, 0, 1, 0, 0, 1, 1, 6'd6, 16'h0000, "R3 write attempt");
        step(0, 0, 1, 0, 1, 1, 1, 6'd6, 0, "R3 read attempt");
        step(0, 0, 1, 0, 1, 0, 0, 6'd6, 0, "R3 readback");

        // Writes blocked in reset (R9)
        step(1, 0, 1, 1, 0, 0, 0, 6'd7, 16'h1357, "R9 write in reset");
        step(0, 0, 1, 0, 1, 0, 0, 6'd7, 0, "R9 readback");

        // Pseudo-random sweep
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[20:16] == 0, rv[0] & rv[1], rv[2] | rv[3], rv[4], rv[5],
                 rv[6], rv[7], rv[13:8], 16'($urandom), "R4 R6 R8 sweep");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule